// File: doc/BRIEF.md
# Quadrature Counter Pin-Function and Index Controller

This block sits between the configuration bus of a dual-axis quadrature counter front end and the up/down counters themselves. For each axis it holds two small configuration registers. The pin-function register decides whether A/B counting is allowed. It also sets the role of the two multipurpose input pins: one pin acts as load-counter or load-output-latch, the other as reset-counter or count gate. The same register routes counter status bits onto two flag outputs. The index register can make either multipurpose pin an encoder index input with a chosen active level. The pin's action then happens in step with the quadrature count enable and no longer on the pin's own edge.

Software writes one 8-bit word per strobe. Bits 6:5 name the target register and bit 7 chooses between the axis named on the axis-select input and both axes at once. The multipurpose pins are asynchronous and pass through a synchronizer chain. The block issues single-cycle load, latch and reset requests to the counter, and a level count gate. The counter itself is outside this block.

Top module: `qcnt_ioctl`

## Requirements
- R1: A write with wr_data[6:5] = 2'b10 stores wr_data[4:0] into the pin-function register. A write with 2'b11 stores wr_data[2:0] into the index register. Codes 2'b00 and 2'b01 change neither register. The new value acts from the cycle after the strobe.
- R2: With wr_data[7] = 0 only the axis whose index equals wr_axis is written. With wr_data[7] = 1 every axis is written and wr_axis is ignored.
- R3: Reset clears both registers on every axis. The count gate is then closed, the index is off, flag1 carries the carry status and flag2 carries the borrow status.
- R4: ab_gate is high when pin-function bit 0 is 1 and, if bit 2 is 1, the synchronized reset/gate pin is also high. When bit 2 is 0, ab_gate follows bit 0 alone.
- R5: With the index off or on the other pin, a rising edge on the load pin gives a one-cycle request two clock edges after the pin change. The request goes on req_ld_cnt when pin-function bit 1 is 0 and on req_ld_latch when bit 1 is 1.
- R6: With pin-function bit 2 = 0 and no index on the pin, a rising edge on the reset/gate pin gives a one-cycle req_rst_cnt two edges later. With bit 2 = 1, req_rst_cnt never asserts.
- R7: Flags follow pin-function bits 4:3. Code 00 gives flag1 = carry and flag2 = borrow. Code 01 gives compare and borrow. Code 10 gives carry OR borrow and direction. Code 11 gives index status and error status.
- R8: Index register bit 0 enables the index, bit 1 sets the active level (1 = high, 0 = low) and bit 2 selects the pin (0 = load pin, 1 = reset/gate pin). While the index is enabled, the selected pin's edge action is suppressed. Its request is issued, combinationally and for one cycle, in the first cycle with qclk_en high that sees the synchronized pin at its active level. It is not issued again until the pin has left its active level.
- R9: An index on the reset/gate pin while pin-function bit 2 = 1 issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Configuration write strobe |
| wr_axis | input | AW | Axis addressed when wr_data[7] is 0 |
| wr_data | input | 8 | Configuration word: [7] all axes, [6:5] target, low bits payload |
| qclk_en | input | NAXIS | Quadrature count enable per axis |
| pin_ld | input | NAXIS | Raw load / latch multipurpose pin |
| pin_rg | input | NAXIS | Raw reset / gate multipurpose pin |
| st_carry | input | NAXIS | Counter carry status |
| st_borrow | input | NAXIS | Counter borrow status |
| st_cmp | input | NAXIS | Counter compare status |
| st_dir | input | NAXIS | Counter up/down status |
| st_idx | input | NAXIS | Index status |
| st_err | input | NAXIS | Error status |
| req_ld_cnt | output | NAXIS | One-cycle load-counter request |
| req_ld_latch | output | NAXIS | One-cycle load-output-latch request |
| req_rst_cnt | output | NAXIS | One-cycle reset-counter request |
| ab_gate | output | NAXIS | A/B counting allowed |
| flag1 | output | NAXIS | First flag output |
| flag2 | output | NAXIS | Second flag output |

## Verification
Register writes show their effect on ab_gate and the flags one edge after the strobe. The bench drives each write on a falling edge and samples at the next falling edge. Pin edges reach the request outputs after two edges, so the bench samples two falling edges after the pin change and again one edge later to confirm the pulse has ended. Index requests are combinational with qclk_en. The bench samples them a quarter period after raising qclk_en, then again after the following edge to show that only one request was issued.

// File: rtl/qio_pkg.sv
package qio_pkg;

  localparam logic [1:0] TGT_PINFN = 2'b10;
  localparam logic [1:0] TGT_INDEX = 2'b11;

  typedef enum logic [1:0] {
    FS_CARRY_BORROW = 2'b00,
    FS_CMP_BORROW   = 2'b01,
    FS_CB_DIR       = 2'b10,
    FS_IDX_ERR      = 2'b11
  } flag_sel_e;

  typedef struct packed {
    flag_sel_e flag_sel;  // [4:3]
    logic      rg_gate;   // [2] reset/gate pin is count gate
    logic      ld_latch;  // [1] load pin loads output latch
    logic      ab_en;     // [0] A/B counting allowed
  } pinfn_cfg_t;

  typedef struct packed {
    logic on_rg;     // [2] index on reset/gate pin
    logic pol_high;  // [1] active-high index
    logic en;        // [0] synchronous index enabled
  } index_cfg_t;

endpackage

// File: rtl/qio_sync.sv
module qio_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/qio_cfg_regs.sv
module qio_cfg_regs
  import qio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       axis_hit,
  input  logic [7:0] wr_data,
  output pinfn_cfg_t pinfn_q,
  output index_cfg_t index_q
);

  pinfn_cfg_t pinfn_d;
  index_cfg_t index_d;
  logic       sel;

  always_comb begin
    sel     = wr_en & (wr_data[7] | axis_hit);
    pinfn_d = pinfn_q;
    index_d = index_q;
    if (sel && wr_data[6:5] == TGT_PINFN) pinfn_d = pinfn_cfg_t'(wr_data[4:0]);
    if (sel && wr_data[6:5] == TGT_INDEX) index_d = index_cfg_t'(wr_data[2:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pinfn_q <= '0;
      index_q <= '0;
    end else begin
      pinfn_q <= pinfn_d;
      index_q <= index_d;
    end
  end

endmodule

// File: rtl/qio_axis.sv
module qio_axis
  import qio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pinfn_cfg_t pinfn,
  input  index_cfg_t index,
  input  logic       qclk_en,
  input  logic       ld_s,
  input  logic       rg_s,
  input  logic       st_carry,
  input  logic       st_borrow,
  input  logic       st_cmp,
  input  logic       st_dir,
  input  logic       st_idx,
  input  logic       st_err,
  output logic       req_ld_cnt,
  output logic       req_ld_latch,
  output logic       req_rst_cnt,
  output logic       ab_gate,
  output logic       flag1,
  output logic       flag2
);

  logic ld_prev_q, rg_prev_q, armed_q;
  logic ld_prev_d, rg_prev_d, armed_d;
  logic ld_rise, rg_rise, idx_pin, idx_act, idx_fire, ld_evt, rg_evt;

  always_comb begin
    ld_rise  = ld_s & ~ld_prev_q;
    rg_rise  = rg_s & ~rg_prev_q;
    idx_pin  = index.on_rg ? rg_s : ld_s;
    idx_act  = index.en & ~(idx_pin ^ index.pol_high);
    idx_fire = idx_act & qclk_en & ~armed_q;

    ld_evt = (index.en && !index.on_rg) ? idx_fire : ld_rise;
    rg_evt = (index.en &&  index.on_rg) ? idx_fire : rg_rise;

    req_ld_cnt   = ld_evt & ~pinfn.ld_latch;
    req_ld_latch = ld_evt &  pinfn.ld_latch;
    req_rst_cnt  = rg_evt & ~pinfn.rg_gate;
    ab_gate      = pinfn.ab_en & (~pinfn.rg_gate | rg_s);

    unique case (pinfn.flag_sel)
      FS_CARRY_BORROW: begin flag1 = st_carry;             flag2 = st_borrow; end
      FS_CMP_BORROW:   begin flag1 = st_cmp;               flag2 = st_borrow; end
      FS_CB_DIR:       begin flag1 = st_carry | st_borrow; flag2 = st_dir;    end
      default:         begin flag1 = st_idx;               flag2 = st_err;    end
    endcase

    ld_prev_d = ld_s;
    rg_prev_d = rg_s;
    armed_d   = idx_act & (armed_q | idx_fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_prev_q <= 1'b0;
      rg_prev_q <= 1'b0;
      armed_q   <= 1'b0;
    end else begin
      ld_prev_q <= ld_prev_d;
      rg_prev_q <= rg_prev_d;
      armed_q   <= armed_d;
    end
  end

endmodule

// File: rtl/qcnt_ioctl.sv
module qcnt_ioctl
  import qio_pkg::*;
#(
  parameter int NAXIS       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = (NAXIS > 1) ? $clog2(NAXIS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_axis,
  input  logic [7:0]       wr_data,
  input  logic [NAXIS-1:0] qclk_en,
  input  logic [NAXIS-1:0] pin_ld,
  input  logic [NAXIS-1:0] pin_rg,
  input  logic [NAXIS-1:0] st_carry,
  input  logic [NAXIS-1:0] st_borrow,
  input  logic [NAXIS-1:0] st_cmp,
  input  logic [NAXIS-1:0] st_dir,
  input  logic [NAXIS-1:0] st_idx,
  input  logic [NAXIS-1:0] st_err,
  output logic [NAXIS-1:0] req_ld_cnt,
  output logic [NAXIS-1:0] req_ld_latch,
  output logic [NAXIS-1:0] req_rst_cnt,
  output logic [NAXIS-1:0] ab_gate,
  output logic [NAXIS-1:0] flag1,
  output logic [NAXIS-1:0] flag2
);

  logic [1:0]             rst_sync_q;
  logic                   rst_n_i;
  logic [NAXIS-1:0]       ld_s, rg_s;
  pinfn_cfg_t [NAXIS-1:0] pinfn_q;
  index_cfg_t [NAXIS-1:0] index_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  qio_sync #(.W(2*NAXIS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     ({pin_rg, pin_ld}),
    .q     ({rg_s, ld_s})
  );

  for (genvar a = 0; a < NAXIS; a++) begin : g_axis
    qio_cfg_regs u_cfg (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .wr_en    (wr_en),
      .axis_hit (wr_axis == AW'(a)),
      .wr_data  (wr_data),
      .pinfn_q  (pinfn_q[a]),
      .index_q  (index_q[a])
    );

    qio_axis u_axis (
      .clk          (clk),
      .rst_n        (rst_n_i),
      .pinfn        (pinfn_q[a]),
      .index        (index_q[a]),
      .qclk_en      (qclk_en[a]),
      .ld_s         (ld_s[a]),
      .rg_s         (rg_s[a]),
      .st_carry     (st_carry[a]),
      .st_borrow    (st_borrow[a]),
      .st_cmp       (st_cmp[a]),
      .st_dir       (st_dir[a]),
      .st_idx       (st_idx[a]),
      .st_err       (st_err[a]),
      .req_ld_cnt   (req_ld_cnt[a]),
      .req_ld_latch (req_ld_latch[a]),
      .req_rst_cnt  (req_rst_cnt[a]),
      .ab_gate      (ab_gate[a]),
      .flag1        (flag1[a]),
      .flag2        (flag2[a])
    );
  end

endmodule

// File: rtl/qcnt_ioctl_chk.sv
module qcnt_ioctl_chk
  import qio_pkg::*;
#(
  parameter int NAXIS = 2,
  localparam int AW   = (NAXIS > 1) ? $clog2(NAXIS) : 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic [AW-1:0]          wr_axis,
  input logic [7:0]             wr_data,
  input logic [NAXIS-1:0]       qclk_en,
  input logic [NAXIS-1:0]       st_carry,
  input logic [NAXIS-1:0]       st_borrow,
  input pinfn_cfg_t [NAXIS-1:0] pinfn_q,
  input index_cfg_t [NAXIS-1:0] index_q,
  input logic [NAXIS-1:0]       req_ld_cnt,
  input logic [NAXIS-1:0]       req_ld_latch,
  input logic [NAXIS-1:0]       req_rst_cnt,
  input logic [NAXIS-1:0]       ab_gate,
  input logic [NAXIS-1:0]       flag1
);

  AST_BCAST_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[7] && wr_data[6:5] == TGT_PINFN) |=> (pinfn_q[0] == pinfn_q[NAXIS-1])); // R2

  for (genvar a = 0; a < NAXIS; a++) begin : g_chk
    AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[6]) |=> (pinfn_q[a] == $past(pinfn_q[a]) && index_q[a] == $past(index_q[a]))); // R1

    AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[6:5] == TGT_PINFN && (wr_data[7] || wr_axis == AW'(a)) && !wr_data[0])
      |=> !ab_gate[a]); // R4

    AST_GATE_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      pinfn_q[a].rg_gate |-> !req_rst_cnt[a]); // R6

    AST_FLAG_CB_OR: assert property (@(posedge clk) disable iff (!rst_n)
      (pinfn_q[a].flag_sel == FS_CB_DIR) |-> (flag1[a] == (st_carry[a] | st_borrow[a]))); // R7

    AST_IDX_ON_QCLK: assert property (@(posedge clk) disable iff (!rst_n)
      (index_q[a].en && !index_q[a].on_rg && (req_ld_cnt[a] || req_ld_latch[a])) |-> qclk_en[a]); // R8

    AST_IDX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (index_q[a].en && index_q[a].on_rg && req_rst_cnt[a])
      |=> !(index_q[a].en && index_q[a].on_rg && req_rst_cnt[a])); // R8
  end

endmodule

bind qcnt_ioctl qcnt_ioctl_chk #(.NAXIS(NAXIS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_i),
  .wr_en        (wr_en),
  .wr_axis      (wr_axis),
  .wr_data      (wr_data),
  .qclk_en      (qclk_en),
  .st_carry     (st_carry),
  .st_borrow    (st_borrow),
  .pinfn_q      (pinfn_q),
  .index_q      (index_q),
  .req_ld_cnt   (req_ld_cnt),
  .req_ld_latch (req_ld_latch),
  .req_rst_cnt  (req_rst_cnt),
  .ab_gate      (ab_gate),
  .flag1        (flag1)
);

// File: tb/qcnt_ioctl_tb.sv
module qcnt_ioctl_tb;

  localparam int CLK_P = 10;
  localparam int NV    = 9;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [0:0] wr_axis;
  logic [7:0] wr_data;
  logic [1:0] qclk_en, pin_ld, pin_rg;
  logic [1:0] st_carry, st_borrow, st_cmp, st_dir, st_idx, st_err;
  logic [1:0] req_ld_cnt, req_ld_latch, req_rst_cnt, ab_gate, flag1, flag2;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  qcnt_ioctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_axis(wr_axis), .wr_data(wr_data),
    .qclk_en(qclk_en), .pin_ld(pin_ld), .pin_rg(pin_rg),
    .st_carry(st_carry), .st_borrow(st_borrow), .st_cmp(st_cmp),
    .st_dir(st_dir), .st_idx(st_idx), .st_err(st_err),
    .req_ld_cnt(req_ld_cnt), .req_ld_latch(req_ld_latch), .req_rst_cnt(req_rst_cnt),
    .ab_gate(ab_gate), .flag1(flag1), .flag2(flag2)
  );

  // {write word, status {carry,borrow,cmp,dir,idx,err}, expected {flag1,flag2,ab_gate}}
  localparam logic [16:0] VEC [NV] = '{
    {8'h41, 6'b100000, 3'b101},
    {8'h40, 6'b010000, 3'b010},
    {8'h49, 6'b101000, 3'b101},
    {8'h49, 6'b100000, 3'b001},
    {8'h51, 6'b010100, 3'b111},
    {8'h51, 6'b000011, 3'b001},
    {8'h58, 6'b100010, 3'b100},
    {8'h59, 6'b110001, 3'b011},
    {8'h45, 6'b000000, 3'b000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic ax, input logic [7:0] d);
    wr_axis = ax; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_axis = '0; wr_data = '0;
    qclk_en = '0; pin_ld = '0; pin_rg = '0;
    st_carry = 2'b11; st_borrow = '0; st_cmp = '0; st_dir = '0; st_idx = '0; st_err = '0;
    idle(4);
    // R3: reset state
    chk("R3 gate", {6'd0, ab_gate}, 8'h00);
    chk("R3 flag1=carry", {6'd0, flag1}, 8'h03);
    chk("R3 flag2=borrow", {6'd0, flag2}, 8'h00);
    rst_n = 1'b1;
    idle(5);
    chk("R3 requests", {2'd0, req_ld_cnt, req_ld_latch, req_rst_cnt}, 8'h00);
    st_carry = '0;

    // R1: reserved target codes change nothing; index code leaves the gate alone
    wr(1'b0, 8'h01);
    chk("R1 code00", {6'd0, ab_gate}, 8'h00);
    wr(1'b0, 8'h21);
    chk("R1 code01", {6'd0, ab_gate}, 8'h00);
    wr(1'b0, 8'h60);
    chk("R1 index code", {6'd0, ab_gate}, 8'h00);

    // R2: axis select and broadcast
    wr(1'b1, 8'h41);
    chk("R2 axis1 only", {6'd0, ab_gate}, 8'h02);
    wr(1'b1, 8'hC1);
    chk("R2 broadcast on", {6'd0, ab_gate}, 8'h03);
    wr(1'b0, 8'hC0);
    chk("R2 broadcast off", {6'd0, ab_gate}, 8'h00);

    // R7 / R4: flag and gate table on axis 0
    for (int i = 0; i < NV; i++) begin
      {st_carry[0], st_borrow[0], st_cmp[0], st_dir[0], st_idx[0], st_err[0]} = VEC[i][8:3];
      wr(1'b0, VEC[i][16:9]);
      chk($sformatf("R7 vec%0d flags", i), {6'd0, flag1[0], flag2[0]}, {6'd0, VEC[i][2:1]});
      chk($sformatf("R4 vec%0d gate", i), {7'd0, ab_gate[0]}, {7'd0, VEC[i][0]});
    end
    {st_carry[0], st_borrow[0], st_cmp[0], st_dir[0], st_idx[0], st_err[0]} = '0;

    // R4: gate mode follows the reset/gate pin; R6: no reset request in gate mode
    pin_rg[0] = 1'b1;
    idle(2);
    chk("R4 gate pin high", {7'd0, ab_gate[0]}, 8'h01);
    chk("R6 gate mode no reset", {7'd0, req_rst_cnt[0]}, 8'h00);
    pin_rg[0] = 1'b0;
    idle(2);
    chk("R4 gate pin low", {7'd0, ab_gate[0]}, 8'h00);
    idle(1);

    // R6: reset-counter pulse
    wr(1'b0, 8'h41);
    pin_rg[0] = 1'b1;
    idle(2);
    chk("R6 reset pulse", {7'd0, req_rst_cnt[0]}, 8'h01);
    idle(1);
    chk("R6 reset pulse end", {7'd0, req_rst_cnt[0]}, 8'h00);
    pin_rg[0] = 1'b0;
    idle(3);

    // R5: load counter then load latch
    pin_ld[0] = 1'b1;
    idle(2);
    chk("R5 load cnt pulse", {6'd0, req_ld_cnt[0], req_ld_latch[0]}, 8'h02);
    idle(1);
    chk("R5 load cnt end", {6'd0, req_ld_cnt[0], req_ld_latch[0]}, 8'h00);
    pin_ld[0] = 1'b0;
    idle(3);
    wr(1'b0, 8'h43);
    pin_ld[0] = 1'b1;
    idle(2);
    chk("R5 load latch pulse", {6'd0, req_ld_cnt[0], req_ld_latch[0]}, 8'h01);
    pin_ld[0] = 1'b0;
    idle(3);

    // R8: active-high index on load pin, load-counter role
    wr(1'b0, 8'h41);
    wr(1'b0, 8'h63);
    pin_ld[0] = 1'b1;
    idle(2);
    chk("R8 edge suppressed", {6'd0, req_ld_cnt[0], req_ld_latch[0]}, 8'h00);
    idle(1);
    qclk_en[0] = 1'b1;
    #(CLK_P/4);
    chk("R8 index on qclk", {7'd0, req_ld_cnt[0]}, 8'h01);
    @(negedge clk);
    chk("R8 index single", {7'd0, req_ld_cnt[0]}, 8'h00);
    qclk_en[0] = 1'b0;
    pin_ld[0] = 1'b0;
    idle(3);

    // R8: active-low index on reset/gate pin
    pin_rg[0] = 1'b1;
    idle(3);
    wr(1'b0, 8'h65);
    pin_rg[0] = 1'b0;
    idle(3);
    chk("R8 low idx waits qclk", {7'd0, req_rst_cnt[0]}, 8'h00);
    qclk_en[0] = 1'b1;
    #(CLK_P/4);
    chk("R8 low idx reset", {7'd0, req_rst_cnt[0]}, 8'h01);
    @(negedge clk);
    qclk_en[0] = 1'b0;

    // R9: index on reset/gate pin while it is a gate has no effect
    pin_rg[0] = 1'b1;
    idle(3);
    wr(1'b0, 8'h45);
    pin_rg[0] = 1'b0;
    idle(3);
    qclk_en[0] = 1'b1;
    #(CLK_P/4);
    chk("R9 gate idx ignored", {7'd0, req_rst_cnt[0]}, 8'h00);
    @(negedge clk);
    chk("R9 gate idx ignored later", {7'd0, req_rst_cnt[0]}, 8'h00);
    qclk_en[0] = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule